// File: doc/BRIEF.md
# Binary to BCD Converter

This block turns an unsigned binary word into packed decimal digits, four bits per digit, with no clock and no state. It uses the shift-and-add-3 method. An accumulator starts at zero. For every input bit, taken from the most significant bit down, each decimal digit of the accumulator that holds 5 or more first gets 3 added to it. The accumulator then moves one place to the left, and the next input bit enters at bit 0. A generate loop builds one such stage for each input bit, so the whole conversion is one combinational path from input to output.

The output holds just enough digits for the largest input value. For the default 12-bit input that is four digits. Digit 0, the units digit, occupies the lowest nibble. Typical uses are driving display digits or formatting readouts from a counter value.

Top module: `bin2bcd_conv`

## Requirements
- R1: For every input value, `bcd_o` read as decimal digits equals the value of `bin_i`.
- R2: Every 4-bit nibble of `bcd_o` holds a value from 0 to 9 for every input.
- R3: Digit 0 (units) sits in `bcd_o[3:0]`, and digit k sits in `bcd_o[4k+3:4k]`, with higher weights in higher nibbles.
- R4: The output has DIGITS = ceil(WIDTH*log10(2)) digits. With WIDTH=12 this is 4 digits, and input 4095 places 4 in digit 3.
- R5: The output follows a change of `bin_i` with no clock edge. It settles within one time unit in simulation.
- R6: Input 0 gives all-zero output. The all-ones input (4095) gives 16'h4095.
- R7: For values below 10^k, every digit at position k or above is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin_i | input | WIDTH | Unsigned binary value to convert |
| bcd_o | output | 4*DIGITS | Packed BCD digits, units digit in the lowest nibble |

## Verification
The bench sweeps all 4096 inputs and compares each result against a reference built by repeated division by ten. This sweep covers every input whose digits carry into the next digit. A correction applied only to the lowest digit, or a threshold of 4 or 6 instead of 5, produces nibbles above 9 or wrong tens and hundreds digits, and the range and value checks report them. The bench also checks the extremes 0 and 4095 and the values on either side of each power of ten. A swapped nibble order or a dropped top digit shows up at these values. Finally, the bench changes the input between clock edges to confirm that the output needs no clock.

// File: rtl/bin2bcd_pkg.sv
package bin2bcd_pkg;
  // digits needed for the largest WIDTH-bit value: ceil(w*log10(2))
  function automatic int unsigned bcd_digits(input int unsigned w);
    int unsigned d;
    d = (w * 30103 + 99999) / 100000;
    return (d == 0) ? 1 : d;
  endfunction
endpackage

// File: rtl/bcd_add3_cell.sv
module bcd_add3_cell (
  input  logic [3:0] dig_i,
  output logic [3:0] dig_o
);
  assign dig_o = (dig_i >= 4'd5) ? dig_i + 4'd3 : dig_i;

  // corrected digit has its top bit set exactly when the input was 5..9
  always_comb begin
    if (dig_i <= 4'd9)
      assert_cell_carry_R2: assert ((dig_i >= 4'd5) == dig_o[3]);
  end
endmodule

// File: rtl/bcd_dd_stage.sv
module bcd_dd_stage #(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned ACC_W = 4 * DIGITS
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] corr;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    bcd_add3_cell u_cell (
      .dig_i (acc_i[4*d +: 4]),
      .dig_o (corr[4*d +: 4])
    );
  end

  assign acc_o = {corr[ACC_W-2:0], bit_i};

  // the bit shifted out must never carry value
  always_comb begin
    assert_no_overflow_R1: assert (corr[ACC_W-1] == 1'b0);
  end
endmodule

// File: rtl/bin2bcd_conv.sv
module bin2bcd_conv #(
  parameter int unsigned WIDTH = 12,
  localparam int unsigned DIGITS = bin2bcd_pkg::bcd_digits(WIDTH),
  localparam int unsigned ACC_W = 4 * DIGITS
) (
  input  logic [WIDTH-1:0] bin_i,
  output logic [ACC_W-1:0] bcd_o
);
  logic [ACC_W-1:0] chain [WIDTH+1];

  assign chain[0] = '0;

  // one add-3/shift stage per input bit, MSB first
  for (genvar s = 0; s < WIDTH; s++) begin : g_stage
    bcd_dd_stage #(.DIGITS(DIGITS)) u_stage (
      .acc_i (chain[s]),
      .bit_i (bin_i[WIDTH-1-s]),
      .acc_o (chain[s+1])
    );
  end

  assign bcd_o = chain[WIDTH];

  always_comb begin
    for (int d = 0; d < DIGITS; d++)
      assert_digit_range_R2: assert (bcd_o[4*d +: 4] <= 4'd9);
    // decimal parity follows binary parity through the units digit
    assert_units_parity_R3: assert (bcd_o[0] == bin_i[0]);
    if (bin_i == '0)
      assert_zero_in_R6: assert (bcd_o == '0);
  end
endmodule

// File: tb/sim_bin2bcd_conv.sv
module sim_bin2bcd_conv;
  localparam int W = 12;
  localparam int ND = 4;

  logic clk = 1'b0;
  logic [W-1:0] bin;
  logic [4*ND-1:0] bcd;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bin2bcd_conv #(.WIDTH(W)) u0 (.bin_i(bin), .bcd_o(bcd));

  function automatic logic [4*ND-1:0] ref_bcd(input int v);
    logic [4*ND-1:0] r = '0;
    for (int k = 0; k < ND; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [4*ND-1:0] act, input logic [4*ND-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: in=%0d act=%h exp=%h", req, bin, act, exp);
    end
  endtask

  task automatic apply(input int v);
    @(posedge clk);
    bin = W'(v);
    @(negedge clk);
  endtask

  initial begin
    logic [4*ND-1:0] q[$];
    bin = '0;
    @(negedge clk);
    chk("R6 zero", bcd, 16'h0000);
    // R1 R2: full sweep against the division-based model
    for (int v = 0; v < (1 << W); v++) q.push_back(ref_bcd(v));
    for (int v = 0; v < (1 << W); v++) begin
      logic [4*ND-1:0] e;
      int bad;
      apply(v);
      e = q.pop_front();
      chk("R1 value", bcd, e);
      bad = 0;
      for (int k = 0; k < ND; k++) if (bcd[4*k +: 4] > 4'd9) bad = 1;
      chk("R2 range", 16'(bad), 16'h0);
    end
    // R3 nibble placement
    apply(7);    chk("R3 units nibble", bcd, 16'h0007);
    apply(80);   chk("R3 tens nibble", bcd, 16'h0080);
    apply(900);  chk("R3 hundreds nibble", bcd, 16'h0900);
    // R4 top digit present
    apply(4095); chk("R4 top digit", {12'h0, bcd[15:12]}, 16'h0004);
    chk("R6 max", bcd, 16'h4095);
    // R7 leading zeros around powers of ten
    apply(9);    chk("R7 below 10", bcd, 16'h0009);
    apply(10);   chk("R7 at 10", bcd, 16'h0010);
    apply(99);   chk("R7 below 100", bcd, 16'h0099);
    apply(100);  chk("R7 at 100", bcd, 16'h0100);
    apply(999);  chk("R7 below 1000", bcd, 16'h0999);
    apply(1000); chk("R7 at 1000", bcd, 16'h1000);
    // R5: change between edges, no clock needed
    @(posedge clk);
    #0.5 bin = W'(1234);
    #1   chk("R5 no clock", bcd, 16'h1234);
    bin = W'(567);
    #1   chk("R5 no clock", bcd, 16'h0567);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: timeout");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule